// File: doc/BRIEF.md
# Hardware Interrupt Acceptance and Transfer Dispatch Unit

This unit sits between a bank of peripheral interrupt sources and a CPU core model. On each instruction-boundary strobe it finds out whether any pending hardware request may be taken. A request is taken when the global enable is set, the source's request and enable flags are set, and the source's programmed level is strictly below the CPU's current level mask. When several sources qualify, the one with the lowest level wins. A tie between equal levels goes to the lowest source index. The CPU also raises the strobe at every step of a repeating string operation, so a request can be taken in the middle of such an instruction.

A taken source whose transfer-service bit is set does not interrupt the CPU. Instead the unit starts one DMA transfer and waits for the transfer engine to acknowledge it. On that acknowledge it writes back the transfer count less one. It enters the CPU interrupt only when that count reaches zero or the peripheral signals that it is finished. On interrupt entry the unit asks for the dedicated registers to be saved on the system stack. It then hands the CPU the new level mask (the source's level), sets the stack flag and gives the vector number. A software trap is entered whatever the enable and mask state; the trap entry clears the global enable. A return-from-interrupt hands back the mask and flags read from the stack.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A hardware source is a candidate only when `cpu_ie`, its `src_req` bit and its `src_en` bit are all 1. If any of them is 0, a boundary strobe produces no accept and no DMA start.
- R2: A candidate is taken only if `cpu_ilm` is strictly greater than its level. An equal mask blocks it, and level 7 can never be taken.
- R3: A taken source whose `src_dma_en` bit is 1 gives a one-cycle `dma_start` with `dma_chan` equal to its index, and gives no `acc_valid`, `stk_save` or `ps_wr` in that cycle.
- R4: On `dma_xfer_ack` during a transfer, the unit pulses `dma_cnt_wr` with `dma_cnt_next` equal to the count sampled at the start less one. In the same cycle it enters the interrupt for that channel if `dma_cnt_next` is 0 or `dma_end_req` is 1. Otherwise it enters nothing.
- R5: A hardware interrupt entry pulses `acc_valid`, `stk_save` and `ps_wr`, with `acc_hw`=1 and `acc_vec`=HW_VEC_BASE+index. It sets `ps_ilm_new` to the source's level, `ps_stk_new`=1 and `ps_ie_new`=`cpu_ie`.
- R6: When no hardware source is taken, `swi_trap` at a boundary is entered whatever `cpu_ie` and `cpu_ilm` hold. It pulses `acc_valid`, `stk_save` and `ps_wr` with `acc_hw`=0, `acc_vec`=`swi_vec`, `ps_ie_new`=0, `ps_stk_new`=1 and `ps_ilm_new`=`cpu_ilm`. A taken hardware request has precedence over a trap at the same boundary.
- R7: Decisions are made only on cycles where `insn_bnd` is 1. With `insn_bnd` at 0, no strobe output rises, whatever the requests are.
- R8: `reti` at a boundary with no hardware request taken pulses `ret_done` and `ps_wr`, with `ps_ilm_new`, `ps_ie_new` and `ps_stk_new` equal to `reti_ilm`, `reti_ie` and `reti_stk`. It raises no `stk_save`.
- R9: Among candidates, the lowest level value wins; equal levels go to the lowest source index.
- R10: Each accept, start, return and count write is a pulse of exactly one cycle, issued in the cycle after the deciding edge.
- R11: While a DMA transfer is outstanding, boundary strobes are ignored: no accept, no start and no return.
- R12: After reset all strobe outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Per-source request flags |
| src_en | input | N_SRC | Per-source enable flags |
| src_lvl | input | N_SRC*LVL_W | Per-source levels, source i at bits [i*LVL_W +: LVL_W] |
| src_dma_en | input | N_SRC | Per-source transfer-service select |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_ilm | input | LVL_W | CPU current level mask |
| cpu_stk | input | 1 | CPU current stack flag |
| insn_bnd | input | 1 | Instruction boundary or string-step strobe |
| swi_trap | input | 1 | Software trap being decoded |
| swi_vec | input | VEC_W | Vector of the software trap |
| reti | input | 1 | Return-from-interrupt being decoded |
| reti_ilm | input | LVL_W | Mask read back from the stack |
| reti_ie | input | 1 | Enable read back from the stack |
| reti_stk | input | 1 | Stack flag read back from the stack |
| dma_cnt | input | CNT_W | Transfer count of the channel being started |
| dma_xfer_ack | input | 1 | Transfer engine finished one transfer |
| dma_end_req | input | 1 | Peripheral requests end of transfer service |
| acc_valid | output | 1 | Interrupt entry strobe |
| acc_hw | output | 1 | 1 hardware entry, 0 software trap |
| acc_vec | output | VEC_W | Entry vector number |
| stk_save | output | 1 | Save dedicated registers to system stack |
| ps_wr | output | 1 | Load new mask and flags into CPU |
| ps_ilm_new | output | LVL_W | New level mask |
| ps_ie_new | output | 1 | New global enable |
| ps_stk_new | output | 1 | New stack flag |
| ret_done | output | 1 | Return restore strobe |
| dma_start | output | 1 | Start one transfer |
| dma_chan | output | IDX_W | Channel to transfer |
| dma_cnt_wr | output | 1 | Write back decremented count |
| dma_cnt_next | output | CNT_W | Decremented count |

## Verification
The bench checks the mask comparison at equality and one step above. A design that compares with greater-or-equal would take a request whose level equals the mask, and the check on the equal case would see an accept. Priority is checked with a lower level at a higher index and with a tie at equal levels. An arbiter that scans in the wrong direction or breaks ties the wrong way reports the wrong vector. The transfer path is checked with a count above one, a count of one, and an early end request. These catch a unit that interrupts after every transfer, one that never interrupts, or one that decrements wrongly. It also checks that boundaries during an outstanding transfer are ignored, and that a trap is still entered when the enable is cleared and the mask is zero.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    SVC_RUN  = 1'b0,
    SVC_XFER = 1'b1
  } svc_state_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ENTRY = 2'd1,
    ACT_TRAP  = 2'd2,
    ACT_RET   = 2'd3
  } act_e;
endpackage

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_SRC-1:0]         req,
  input  logic [N_SRC-1:0]         en,
  input  logic [N_SRC*LVL_W-1:0]   lvl,
  input  logic [N_SRC-1:0]         dma_sel,
  input  logic                     gie,
  input  logic [LVL_W-1:0]         mask,
  output logic                     win_valid,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl,
  output logic                     win_dma
);
  logic [N_SRC-1:0] cand;
  logic [LVL_W-1:0] lvl_a [N_SRC];

  // Candidate qualification per source: flags and strict mask compare.
  for (genvar g = 0; g < N_SRC; g++) begin : g_cand
    assign lvl_a[g] = lvl[g*LVL_W +: LVL_W];
    assign cand[g]  = gie & req[g] & en[g] & (lvl_a[g] < mask);
  end

  // Lowest level wins; ascending scan with strict compare keeps lowest index on ties.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!win_valid || (lvl_a[i] < win_lvl))) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl_a[i];
      end
    end
    win_dma = win_valid & dma_sel[win_idx];
  end

  assert_win_enabled_R1: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (gie && req[win_idx] && en[win_idx]));
  assert_win_below_mask_R2: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (lvl_a[win_idx] < mask));
endmodule

// File: rtl/irq_xfer_track.sv
module irq_xfer_track
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  parameter int CNT_W = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] start_chan,
  input  logic [LVL_W-1:0] start_lvl,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             xfer_ack,
  input  logic             end_req,
  output logic             busy,
  output logic             svc_done,
  output logic             raise_irq,
  output logic [IDX_W-1:0] chan,
  output logic [LVL_W-1:0] chan_lvl,
  output logic [CNT_W-1:0] cnt_next
);
  svc_state_e       state;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SVC_RUN;
      cnt_q    <= '0;
      chan     <= '0;
      chan_lvl <= '0;
    end else begin
      case (state)
        SVC_RUN: if (start) begin
          state    <= SVC_XFER;
          cnt_q    <= start_cnt;
          chan     <= start_chan;
          chan_lvl <= start_lvl;
        end
        SVC_XFER: if (xfer_ack) state <= SVC_RUN;
        default: state <= SVC_RUN;
      endcase
    end
  end

  assign busy      = (state == SVC_XFER);
  assign svc_done  = busy & xfer_ack;
  assign cnt_next  = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
  assign raise_irq = svc_done & ((cnt_next == '0) | end_req);

  assert_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
  assert_one_service_R4: assert property (@(posedge clk) disable iff (rst)
    svc_done |=> !busy);
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC       = 8,
  parameter int LVL_W       = 3,
  parameter int CNT_W       = 8,
  parameter int VEC_W       = 8,
  parameter int HW_VEC_BASE = 32,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       src_req,
  input  logic [N_SRC-1:0]       src_en,
  input  logic [N_SRC*LVL_W-1:0] src_lvl,
  input  logic [N_SRC-1:0]       src_dma_en,
  input  logic                   cpu_ie,
  input  logic [LVL_W-1:0]       cpu_ilm,
  input  logic                   cpu_stk,
  input  logic                   insn_bnd,
  input  logic                   swi_trap,
  input  logic [VEC_W-1:0]       swi_vec,
  input  logic                   reti,
  input  logic [LVL_W-1:0]       reti_ilm,
  input  logic                   reti_ie,
  input  logic                   reti_stk,
  input  logic [CNT_W-1:0]       dma_cnt,
  input  logic                   dma_xfer_ack,
  input  logic                   dma_end_req,
  output logic                   acc_valid,
  output logic                   acc_hw,
  output logic [VEC_W-1:0]       acc_vec,
  output logic                   stk_save,
  output logic                   ps_wr,
  output logic [LVL_W-1:0]       ps_ilm_new,
  output logic                   ps_ie_new,
  output logic                   ps_stk_new,
  output logic                   ret_done,
  output logic                   dma_start,
  output logic [IDX_W-1:0]       dma_chan,
  output logic                   dma_cnt_wr,
  output logic [CNT_W-1:0]       dma_cnt_next
);
  logic             win_valid, win_dma;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic             xf_busy, xf_done, xf_raise;
  logic [IDX_W-1:0] xf_chan;
  logic [LVL_W-1:0] xf_lvl;
  logic [CNT_W-1:0] xf_cnt_next;
  logic             bnd_ok, go_xfer, entry_from_xfer;
  act_e             act;

  irq_level_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst(rst), .req(src_req), .en(src_en), .lvl(src_lvl),
    .dma_sel(src_dma_en), .gie(cpu_ie), .mask(cpu_ilm),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl), .win_dma(win_dma)
  );

  assign bnd_ok  = insn_bnd & ~xf_busy;
  assign go_xfer = bnd_ok & win_valid & win_dma;

  irq_xfer_track #(.N_SRC(N_SRC), .LVL_W(LVL_W), .CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst(rst), .start(go_xfer), .start_chan(win_idx),
    .start_lvl(win_lvl), .start_cnt(dma_cnt), .xfer_ack(dma_xfer_ack),
    .end_req(dma_end_req), .busy(xf_busy), .svc_done(xf_done),
    .raise_irq(xf_raise), .chan(xf_chan), .chan_lvl(xf_lvl), .cnt_next(xf_cnt_next)
  );

  // Decision for this edge: hardware before trap before return.
  always_comb begin
    act = ACT_NONE;
    if (xf_raise)                         act = ACT_ENTRY;
    else if (bnd_ok && win_valid && !win_dma) act = ACT_ENTRY;
    else if (bnd_ok && !win_valid && swi_trap) act = ACT_TRAP;
    else if (bnd_ok && !win_valid && reti)     act = ACT_RET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_valid       <= 1'b0;
      acc_hw          <= 1'b0;
      acc_vec         <= '0;
      stk_save        <= 1'b0;
      ps_wr           <= 1'b0;
      ps_ilm_new      <= '0;
      ps_ie_new       <= 1'b0;
      ps_stk_new      <= 1'b0;
      ret_done        <= 1'b0;
      dma_start       <= 1'b0;
      dma_chan        <= '0;
      dma_cnt_wr      <= 1'b0;
      dma_cnt_next    <= '0;
      entry_from_xfer <= 1'b0;
    end else begin
      acc_valid       <= 1'b0;
      stk_save        <= 1'b0;
      ps_wr           <= 1'b0;
      ret_done        <= 1'b0;
      dma_start       <= 1'b0;
      dma_cnt_wr      <= 1'b0;
      entry_from_xfer <= 1'b0;
      if (xf_done) begin
        dma_cnt_wr   <= 1'b1;
        dma_cnt_next <= xf_cnt_next;
      end
      if (go_xfer) begin
        dma_start <= 1'b1;
        dma_chan  <= win_idx;
      end
      case (act)
        ACT_ENTRY: begin
          acc_valid       <= 1'b1;
          acc_hw          <= 1'b1;
          stk_save        <= 1'b1;
          ps_wr           <= 1'b1;
          ps_ie_new       <= cpu_ie;
          ps_stk_new      <= 1'b1;
          entry_from_xfer <= xf_raise;
          if (xf_raise) begin
            acc_vec    <= VEC_W'(HW_VEC_BASE) + VEC_W'(xf_chan);
            ps_ilm_new <= xf_lvl;
          end else begin
            acc_vec    <= VEC_W'(HW_VEC_BASE) + VEC_W'(win_idx);
            ps_ilm_new <= win_lvl;
          end
        end
        ACT_TRAP: begin
          acc_valid  <= 1'b1;
          acc_hw     <= 1'b0;
          acc_vec    <= swi_vec;
          stk_save   <= 1'b1;
          ps_wr      <= 1'b1;
          ps_ie_new  <= 1'b0;
          ps_stk_new <= 1'b1;
          ps_ilm_new <= cpu_ilm;
        end
        ACT_RET: begin
          ret_done   <= 1'b1;
          ps_wr      <= 1'b1;
          ps_ilm_new <= reti_ilm;
          ps_ie_new  <= reti_ie;
          ps_stk_new <= reti_stk;
        end
        default: ;
      endcase
    end
  end

  // cpu_stk is status only; entry always forces the stack flag.
  logic unused_stk;
  assign unused_stk = cpu_stk;

  assert_strict_mask_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_hw && !entry_from_xfer) |-> (ps_ilm_new < $past(cpu_ilm)));
  assert_xfer_no_entry_R3: assert property (@(posedge clk) disable iff (rst)
    dma_start |-> (!acc_valid && !stk_save));
  assert_entry_saves_R5: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> (stk_save && ps_wr && ps_stk_new));
  assert_trap_clears_ie_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_hw) |-> !ps_ie_new);
  assert_only_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ret_done) |-> $past(insn_bnd));
  assert_ret_no_save_R8: assert property (@(posedge clk) disable iff (rst)
    ret_done |-> (!stk_save && ps_wr));
  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    dma_start |=> !dma_start);
endmodule

// File: tb/irq_accept_ctrl_bench.sv
`timescale 1ns/1ps
module irq_accept_ctrl_bench;
  localparam int N = 8, LW = 3, CW = 8, VW = 8, BASE = 32;
  logic clk = 0, rst = 1;
  logic [N-1:0] src_req = 0, src_en = 0, src_dma_en = 0;
  logic [N*LW-1:0] src_lvl = '1;
  logic cpu_ie = 0, cpu_stk = 0, insn_bnd = 0, swi_trap = 0, reti = 0;
  logic [LW-1:0] cpu_ilm = 7, reti_ilm = 0;
  logic reti_ie = 0, reti_stk = 0, dma_xfer_ack = 0, dma_end_req = 0;
  logic [VW-1:0] swi_vec = 0;
  logic [CW-1:0] dma_cnt = 0;
  logic acc_valid, acc_hw, stk_save, ps_wr, ps_ie_new, ps_stk_new, ret_done;
  logic dma_start, dma_cnt_wr;
  logic [VW-1:0] acc_vec;
  logic [LW-1:0] ps_ilm_new;
  logic [2:0] dma_chan;
  logic [CW-1:0] dma_cnt_next;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_accept_ctrl #(.N_SRC(N), .LVL_W(LW), .CNT_W(CW), .VEC_W(VW), .HW_VEC_BASE(BASE))
  u_irq_accept_ctrl (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_lvl(input int i, input int l);
    src_lvl[i*LW +: LW] = LW'(l);
  endtask

  task automatic clear_all();
    src_req = 0; src_en = 0; src_dma_en = 0; src_lvl = '1;
    swi_trap = 0; reti = 0; dma_end_req = 0; dma_xfer_ack = 0;
  endtask

  // Pulse a boundary for one cycle; outputs checked one edge later.
  task automatic boundary();
    insn_bnd = 1;
    @(posedge clk); @(negedge clk);
    insn_bnd = 0;
  endtask

  task automatic ack();
    dma_xfer_ack = 1;
    @(posedge clk); @(negedge clk);
    dma_xfer_ack = 0;
  endtask

  task automatic t_reset();
    chk(!acc_valid && !dma_start && !ps_wr && !stk_save && !ret_done && !dma_cnt_wr,
        "R12 strobes low after reset", acc_valid, 0);
  endtask

  task automatic t_no_strobe();
    clear_all(); cpu_ie = 1; cpu_ilm = 7;
    src_req[2] = 1; src_en[2] = 1; set_lvl(2, 1);
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      chk(!acc_valid && !dma_start, "R7 no boundary no accept", acc_valid, 0);
    end
  endtask

  task automatic t_gating();
    clear_all(); cpu_ilm = 7; set_lvl(3, 2);
    cpu_ie = 0; src_req[3] = 1; src_en[3] = 1; boundary();
    chk(!acc_valid, "R1 global enable off", acc_valid, 0);
    cpu_ie = 1; src_en[3] = 0; boundary();
    chk(!acc_valid, "R1 source enable off", acc_valid, 0);
    src_en[3] = 1; src_req[3] = 0; boundary();
    chk(!acc_valid, "R1 request off", acc_valid, 0);
  endtask

  task automatic t_mask();
    clear_all(); cpu_ie = 1; src_req[4] = 1; src_en[4] = 1; set_lvl(4, 3);
    cpu_ilm = 3; boundary();
    chk(!acc_valid, "R2 equal mask blocks", acc_valid, 0);
    cpu_ilm = 4; boundary();
    chk(acc_valid && acc_hw, "R2 mask above level accepts", acc_valid, 1);
    chk(acc_vec == BASE + 4, "R5 vector", acc_vec, BASE + 4);
    chk(ps_ilm_new == 3 && ps_stk_new && stk_save && ps_wr && ps_ie_new,
        "R5 entry mask and flags", ps_ilm_new, 3);
    @(posedge clk); @(negedge clk);
    chk(!acc_valid && !stk_save, "R10 accept is one cycle", acc_valid, 0);
    clear_all(); src_req[0] = 1; src_en[0] = 1; set_lvl(0, 7); cpu_ilm = 7; boundary();
    chk(!acc_valid, "R2 level 7 never taken", acc_valid, 0);
  endtask

  task automatic t_priority();
    clear_all(); cpu_ie = 1; cpu_ilm = 7;
    src_req = 8'b0110_0100; src_en = 8'hFF;
    set_lvl(2, 5); set_lvl(5, 2); set_lvl(6, 2);
    boundary();
    chk(acc_valid && acc_vec == BASE + 5, "R9 lowest level then lowest index", acc_vec, BASE + 5);
    clear_all(); src_req = 8'b0000_1010; src_en = 8'hFF; set_lvl(1, 4); set_lvl(3, 4);
    boundary();
    chk(acc_valid && acc_vec == BASE + 1, "R9 tie to lowest index", acc_vec, BASE + 1);
    chk(ps_ilm_new == 4, "R5 level loaded", ps_ilm_new, 4);
  endtask

  task automatic t_trap();
    clear_all(); cpu_ie = 0; cpu_ilm = 0; swi_trap = 1; swi_vec = 8'h40;
    boundary();
    chk(acc_valid && !acc_hw && acc_vec == 8'h40, "R6 trap entered", acc_vec, 8'h40);
    chk(!ps_ie_new && ps_stk_new && ps_ilm_new == 0 && stk_save, "R6 trap clears enable",
        ps_ie_new, 0);
    clear_all(); cpu_ie = 1; cpu_ilm = 6; swi_trap = 1;
    src_req[7] = 1; src_en[7] = 1; set_lvl(7, 1);
    boundary();
    chk(acc_valid && acc_hw && acc_vec == BASE + 7, "R6 hardware before trap", acc_vec, BASE + 7);
  endtask

  task automatic t_reti();
    clear_all(); cpu_ie = 0; cpu_ilm = 2; reti = 1; reti_ilm = 5; reti_ie = 1; reti_stk = 0;
    boundary();
    chk(ret_done && ps_wr && !stk_save && !acc_valid, "R8 return strobe", ret_done, 1);
    chk(ps_ilm_new == 5 && ps_ie_new && !ps_stk_new, "R8 restored mask", ps_ilm_new, 5);
  endtask

  task automatic t_dma();
    clear_all(); cpu_ie = 1; cpu_ilm = 7;
    src_req[4] = 1; src_en[4] = 1; src_dma_en[4] = 1; set_lvl(4, 2); dma_cnt = 3;
    boundary();
    chk(dma_start && dma_chan == 4, "R3 transfer started", dma_chan, 4);
    chk(!acc_valid && !stk_save && !ps_wr, "R3 no entry on start", acc_valid, 0);
    src_req[1] = 1; src_en[1] = 1; set_lvl(1, 0); boundary();
    chk(!acc_valid && !dma_start, "R11 boundary ignored while busy", acc_valid, 0);
    src_req[1] = 0;
    ack();
    chk(dma_cnt_wr && dma_cnt_next == 2, "R4 count written", dma_cnt_next, 2);
    chk(!acc_valid, "R4 no entry with count left", acc_valid, 0);
    dma_cnt = 1; boundary();
    chk(dma_start, "R3 second start", dma_start, 1);
    ack();
    chk(dma_cnt_wr && dma_cnt_next == 0, "R4 count exhausted", dma_cnt_next, 0);
    chk(acc_valid && acc_hw && acc_vec == BASE + 4 && ps_ilm_new == 2, "R4 entry on exhaust",
        acc_vec, BASE + 4);
    dma_cnt = 5; boundary();
    dma_end_req = 1; ack(); dma_end_req = 0;
    chk(dma_cnt_next == 4 && acc_valid && acc_vec == BASE + 4, "R4 entry on end request",
        acc_valid, 1);
    @(posedge clk); @(negedge clk);
    chk(!dma_cnt_wr && !acc_valid, "R10 count write one cycle", dma_cnt_wr, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    t_reset();
    t_no_strobe();
    t_gating();
    t_mask();
    t_priority();
    t_trap();
    t_reti();
    t_dma();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule